// File: doc/BRIEF.md
# Burst-Aligned Frame Buffer Address Generator

This block turns one frame-buffer access request into a series of burst commands for a memory read master or a memory write master. A start pulse captures the buffer base address, the frame size in memory words, which master is being served, the two burst targets and an alignment switch. The block then offers one command at a time on a valid/ready handshake until the whole frame is covered. Each command carries a start address, a length and a write flag.

Burst targets are powers of two, given as their base-2 logarithm. With alignment switched on, every burst start is rounded up to a multiple of the alignment unit, so that no burst straddles a memory row. The alignment unit is the larger of the read and write targets. The gaps this leaves are counted in a frame stride output, which gives the buffer span the frame really occupies. The whole block runs on the memory clock, so the command outputs live in the same clock domain as the masters.

Top module: `fb_burst_addr_gen`

## Requirements
- R1: After reset, cmd_valid, busy and done are 0 and frame_stride is 0.
- R2: A start pulse taken while idle makes the first command visible on the next cycle. cmd_write is equal to the start_write value that was captured (1 selects the write master, 0 the read master).
- R3: Every burst has length 2^T, where T is the selected target. The exception is the last burst, which carries the words that remain. The lengths add up to frame_words, and no burst is empty.
- R4: When alignment is off, the first address equals base_addr, and each following address equals the previous address plus the previous length.
- R5: When alignment is on, every burst start is a multiple of 2^U, where U = max(read target, write target). The first address is base_addr rounded up to that multiple. Each following address is the previous end address rounded up in the same way.
- R6: A write frame uses wr_burst_log2 as T, and a read frame uses rd_burst_log2.
- R7: While cmd_valid is 1 and cmd_ready is 0, cmd_addr, cmd_len and cmd_write hold steady. The command advances only on a cycle in which both are 1.
- R8: On the cycle after the final handshake, cmd_valid and busy are 0 and done is 1 for that cycle.
- R9: In the cycle where done is 1, frame_stride equals the end of the last burst minus the captured base. When alignment is on, that end is first rounded up to 2^U.
- R10: A start pulse with frame_words = 0 issues no command. It raises done on the next cycle with frame_stride = 0.
- R11: A start pulse while busy has no effect, and this includes the cycle of the final handshake. A start pulse in the cycle where done is 1 is accepted.
- R12: A target log value above MAX_BURST_LOG2 is treated as MAX_BURST_LOG2, both as a burst length and for the alignment unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; captures the request fields when idle |
| start_write | input | 1 | 1 = serve the write master, 0 = serve the read master |
| base_addr | input | ADDR_W | Buffer base word address |
| frame_words | input | LEN_W | Frame size in memory words |
| rd_burst_log2 | input | TLOG_W | log2 of the read burst target |
| wr_burst_log2 | input | TLOG_W | log2 of the write burst target |
| align_en | input | 1 | Round burst starts up to the alignment unit |
| cmd_ready | input | 1 | Master accepts the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd_addr | output | ADDR_W | Burst start word address |
| cmd_len | output | MAX_BURST_LOG2+1 | Burst length in words |
| cmd_write | output | 1 | Command belongs to the write master |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame is complete |
| frame_stride | output | ADDR_W | Span the frame occupies, including alignment padding |

## Verification
Two events can land on the same clock edge: the handshake that retires the last burst, and a fresh start pulse. The bench drives start together with cmd_ready on the final burst. It expects the start to be dropped: cmd_valid stays low on the two following cycles. It also drives a start in the cycle where done is 1 and expects that request to be served on the next cycle. Stalls set by a fixed ready pattern, and a start poked in mid-frame, show whether commands hold and whether the captured request survives.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fbag_state_e;

endpackage

// File: rtl/fbag_unit_sel.sv
module fbag_unit_sel #(
  parameter int MAX_BURST_LOG2 = 8,
  parameter int TLOG_W         = 4
) (
  input  logic [TLOG_W-1:0] rd_log,
  input  logic [TLOG_W-1:0] wr_log,
  input  logic              sel_write,
  output logic [TLOG_W-1:0] tgt_log,
  output logic [TLOG_W-1:0] unit_log
);

  localparam logic [TLOG_W-1:0] LOG_CAP = TLOG_W'(MAX_BURST_LOG2);

  logic [TLOG_W-1:0] raw_log [2];
  logic [TLOG_W-1:0] cap_log [2];

  assign raw_log[0] = rd_log;
  assign raw_log[1] = wr_log;

  // Clamp each side to the largest supported burst.
  for (genvar g = 0; g < 2; g++) begin : g_clamp
    assign cap_log[g] = (raw_log[g] > LOG_CAP) ? LOG_CAP : raw_log[g];
  end

  assign tgt_log  = sel_write ? cap_log[1] : cap_log[0];
  assign unit_log = (cap_log[0] > cap_log[1]) ? cap_log[0] : cap_log[1];

endmodule

// File: rtl/fbag_round_up.sv
module fbag_round_up #(
  parameter int ADDR_W = 32,
  parameter int TLOG_W = 4
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [TLOG_W-1:0] unit_log,
  input  logic              align,
  output logic [ADDR_W-1:0] addr_out
);

  logic [ADDR_W-1:0] low_mask;

  assign low_mask = (ADDR_W'(1) << unit_log) - ADDR_W'(1);
  assign addr_out = align ? ((addr_in + low_mask) & ~low_mask) : addr_in;

endmodule

// File: rtl/fbag_sequencer.sv
module fbag_sequencer
  import fbag_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 24,
  parameter int MAX_BURST_LOG2 = 8,
  parameter int TLOG_W         = 4,
  localparam int BURST_W       = MAX_BURST_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  frame_words,
  input  logic [TLOG_W-1:0] sel_tgt_log,
  input  logic [TLOG_W-1:0] sel_unit_log,
  input  logic              align_en,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BURST_W-1:0] cmd_len,
  output logic              cmd_write,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] frame_stride
);

  fbag_state_e       state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [BURST_W-1:0] len_q;
  logic [TLOG_W-1:0] tlog_q;
  logic [TLOG_W-1:0] ulog_q;
  logic              align_q;
  logic              write_q;
  logic              done_q;
  logic [ADDR_W-1:0] stride_q;

  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] end_addr;
  logic [ADDR_W-1:0] next_addr;
  logic [LEN_W-1:0]  rem_after;
  logic              fire;

  function automatic logic [BURST_W-1:0] burst_len(input logic [LEN_W-1:0] left,
                                                   input logic [TLOG_W-1:0] tl);
    logic [LEN_W-1:0] full;
    full = LEN_W'(1) << tl;
    return (left >= full) ? BURST_W'(full) : BURST_W'(left);
  endfunction

  assign fire      = (state_q == ST_RUN) && cmd_ready;
  assign end_addr  = addr_q + ADDR_W'(len_q);
  assign rem_after = rem_q - LEN_W'(len_q);

  fbag_round_up #(.ADDR_W(ADDR_W), .TLOG_W(TLOG_W)) u_first (
    .addr_in  (base_addr),
    .unit_log (sel_unit_log),
    .align    (align_en),
    .addr_out (first_addr)
  );

  fbag_round_up #(.ADDR_W(ADDR_W), .TLOG_W(TLOG_W)) u_next (
    .addr_in  (end_addr),
    .unit_log (ulog_q),
    .align    (align_q),
    .addr_out (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      len_q    <= '0;
      tlog_q   <= '0;
      ulog_q   <= '0;
      align_q  <= 1'b0;
      write_q  <= 1'b0;
      done_q   <= 1'b0;
      stride_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          base_q  <= base_addr;
          write_q <= start_write;
          tlog_q  <= sel_tgt_log;
          ulog_q  <= sel_unit_log;
          align_q <= align_en;
          if (frame_words == '0) begin
            done_q   <= 1'b1;
            stride_q <= '0;
          end else begin
            state_q <= ST_RUN;
            addr_q  <= first_addr;
            rem_q   <= frame_words;
            len_q   <= burst_len(frame_words, sel_tgt_log);
          end
        end
      end else if (fire) begin
        if (rem_after == '0) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          stride_q <= next_addr - base_q;
        end else begin
          addr_q <= next_addr;
          rem_q  <= rem_after;
          len_q  <= burst_len(rem_after, tlog_q);
        end
      end
    end
  end

  assign cmd_valid    = (state_q == ST_RUN);
  assign busy         = (state_q == ST_RUN);
  assign cmd_addr     = addr_q;
  assign cmd_len      = len_q;
  assign cmd_write    = write_q;
  assign done         = done_q;
  assign frame_stride = stride_q;

  // R7: an offered command that is not taken stays as it was
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_write));

  // R5: aligned starts have no bits set below the unit
  a_r5_start_aligned: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && align_q |-> (cmd_addr & ((ADDR_W'(1) << ulog_q) - ADDR_W'(1))) == '0);

  // R3: a burst is never empty, never above target, never past the frame end
  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len != '0) && (LEN_W'(cmd_len) <= (LEN_W'(1) << tlog_q)) && (LEN_W'(cmd_len) <= rem_q));

  // R8: completion never overlaps an offered command
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid && !busy);

  // R11: a start pulse during a frame leaves the captured request alone
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(base_q) && $stable(write_q));

endmodule

// File: rtl/fb_burst_addr_gen.sv
module fb_burst_addr_gen #(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 24,
  parameter int MAX_BURST_LOG2 = 8,
  localparam int TLOG_W        = $clog2(MAX_BURST_LOG2 + 1),
  localparam int BURST_W       = MAX_BURST_LOG2 + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_write,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [LEN_W-1:0]   frame_words,
  input  logic [TLOG_W-1:0]  rd_burst_log2,
  input  logic [TLOG_W-1:0]  wr_burst_log2,
  input  logic               align_en,
  input  logic               cmd_ready,
  output logic               cmd_valid,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [BURST_W-1:0] cmd_len,
  output logic               cmd_write,
  output logic               busy,
  output logic               done,
  output logic [ADDR_W-1:0]  frame_stride
);

  logic [TLOG_W-1:0] tgt_log;
  logic [TLOG_W-1:0] unit_log;

  fbag_unit_sel #(
    .MAX_BURST_LOG2 (MAX_BURST_LOG2),
    .TLOG_W         (TLOG_W)
  ) u_unit (
    .rd_log    (rd_burst_log2),
    .wr_log    (wr_burst_log2),
    .sel_write (start_write),
    .tgt_log   (tgt_log),
    .unit_log  (unit_log)
  );

  fbag_sequencer #(
    .ADDR_W         (ADDR_W),
    .LEN_W          (LEN_W),
    .MAX_BURST_LOG2 (MAX_BURST_LOG2),
    .TLOG_W         (TLOG_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_write  (start_write),
    .base_addr    (base_addr),
    .frame_words  (frame_words),
    .sel_tgt_log  (tgt_log),
    .sel_unit_log (unit_log),
    .align_en     (align_en),
    .cmd_ready    (cmd_ready),
    .cmd_valid    (cmd_valid),
    .cmd_addr     (cmd_addr),
    .cmd_len      (cmd_len),
    .cmd_write    (cmd_write),
    .busy         (busy),
    .done         (done),
    .frame_stride (frame_stride)
  );

endmodule

// File: tb/sim_fb_burst_addr_gen.sv
module sim_fb_burst_addr_gen;

  localparam int AW   = 32;
  localparam int LW   = 16;
  localparam int MAXL = 6;
  localparam int TW   = $clog2(MAXL + 1);
  localparam int BW   = MAXL + 1;

  typedef struct packed {
    logic          wr;
    logic [31:0]   base;
    logic [15:0]   frame;
    logic [2:0]    rdl;
    logic [2:0]    wrl;
    logic          al;
    logic [7:0]    nbursts;
    logic [31:0]   stride;
  } vec_t;

  // Expected burst counts and strides are worked out by hand from R3..R9, R12.
  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h100, 16'd40, 3'd4, 3'd3, 1'b0, 8'd3, 32'd40},
    '{1'b1, 32'h103, 16'd20, 3'd2, 3'd3, 1'b1, 8'd3, 32'd29},
    '{1'b0, 32'h205, 16'd10, 3'd2, 3'd4, 1'b1, 8'd3, 32'd59},
    '{1'b1, 32'h040, 16'd64, 3'd6, 3'd6, 1'b0, 8'd1, 32'd64},
    '{1'b0, 32'h007, 16'd5,  3'd7, 3'd1, 1'b1, 8'd1, 32'd121},
    '{1'b1, 32'h010, 16'd3,  3'd0, 3'd0, 1'b1, 8'd3, 32'd3}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          start_write = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] frame_words = '0;
  logic [TW-1:0] rd_burst_log2 = '0;
  logic [TW-1:0] wr_burst_log2 = '0;
  logic          align_en = 1'b0;
  logic          cmd_ready = 1'b0;
  logic          cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] cmd_len;
  logic          cmd_write;
  logic          busy;
  logic          done;
  logic [AW-1:0] frame_stride;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fb_burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .MAX_BURST_LOG2(MAXL)) u0 (
    .clk, .rst, .start, .start_write, .base_addr, .frame_words,
    .rd_burst_log2, .wr_burst_log2, .align_en, .cmd_ready,
    .cmd_valid, .cmd_addr, .cmd_len, .cmd_write, .busy, .done, .frame_stride
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rup(input logic [31:0] a, input int ul, input bit al);
    logic [31:0] m;
    m = (32'd1 << ul) - 32'd1;
    return al ? ((a + m) & ~m) : a;
  endfunction

  function automatic int capl(input int l);
    return (l > MAXL) ? MAXL : l;
  endfunction

  task automatic run_vec(input vec_t v, input bit poke, input bit collide);
    int tl, ul, rem, nb, step, len;
    logic [31:0] addr;
    bit rdy;
    tl   = capl(v.wr ? int'(v.wrl) : int'(v.rdl));
    ul   = (capl(int'(v.rdl)) > capl(int'(v.wrl))) ? capl(int'(v.rdl)) : capl(int'(v.wrl));
    rem  = int'(v.frame);
    addr = rup(v.base, ul, v.al);
    nb   = 0;
    step = 0;
    @(negedge clk);
    start = 1'b1; start_write = v.wr; base_addr = v.base; frame_words = v.frame;
    rd_burst_log2 = v.rdl; wr_burst_log2 = v.wrl; align_en = v.al;
    @(negedge clk);
    start = 1'b0;
    while (rem > 0 && !finished) begin
      len = (rem >= (1 << tl)) ? (1 << tl) : rem;
      chk(cmd_valid == 1'b1, "R2 R7 command offered", 32'(cmd_valid), 32'd1);
      chk(cmd_addr == addr, "R4 R5 burst address", cmd_addr, addr);
      chk(int'(cmd_len) == len, "R3 R6 R12 burst length", 32'(cmd_len), 32'(len));
      chk(cmd_write == v.wr, "R2 write flag", 32'(cmd_write), 32'(v.wr));
      rdy = (step % 3) != 1;
      if (poke && step == 0) begin
        start = 1'b1; base_addr = 32'hDEAD0; frame_words = 16'd7; start_write = ~v.wr;
      end
      if (collide && rdy && len == rem) begin
        start = 1'b1; base_addr = 32'hBEEF0; frame_words = 16'd9;
      end
      cmd_ready = rdy;
      @(negedge clk);
      start = 1'b0; cmd_ready = 1'b0;
      if (rdy) begin
        rem  = rem - len;
        addr = rup(addr + 32'(len), ul, v.al);
        nb++;
      end
      step++;
    end
    chk(cmd_valid == 1'b0 && busy == 1'b0, "R8 idle after last burst", {cmd_valid, busy}, 32'd0);
    chk(done == 1'b1, "R8 done pulse", 32'(done), 32'd1);
    chk(frame_stride == v.stride, "R9 frame stride", frame_stride, v.stride);
    chk(nb == int'(v.nbursts), "R3 burst count", 32'(nb), 32'(v.nbursts));
    if (collide) begin
      @(negedge clk);
      chk(cmd_valid == 1'b0 && done == 1'b0, "R11 start at final handshake dropped",
          {cmd_valid, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_valid == 1'b0, "R1 valid after reset", 32'(cmd_valid), 32'd0);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", {busy, done}, 32'd0);
    chk(frame_stride == '0, "R1 stride after reset", frame_stride, 32'd0);

    // Vector table walk; entry 0 pokes start mid-frame (R11), entry 5 collides with the last handshake
    for (int i = 0; i < 6; i++) begin
      run_vec(VECS[i], i == 0, i == 5);
    end

    // R10 zero-size frame, then R11 start accepted in the done cycle
    @(negedge clk);
    start = 1'b1; frame_words = '0; base_addr = 32'h300; align_en = 1'b1;
    @(negedge clk);
    chk(done == 1'b1 && cmd_valid == 1'b0, "R10 zero frame completes", {done, cmd_valid}, 32'h2);
    chk(frame_stride == '0, "R10 zero frame stride", frame_stride, 32'd0);
    start = 1'b1; start_write = 1'b0; frame_words = 16'd2; base_addr = 32'h50;
    rd_burst_log2 = 3'd3; align_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(cmd_valid == 1'b1 && cmd_addr == 32'h50, "R11 start in done cycle accepted",
        cmd_addr, 32'h50);
    chk(cmd_len == BW'(2), "R3 short frame length", 32'(cmd_len), 32'd2);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(done == 1'b1 && frame_stride == 32'd2, "R9 stride short frame", frame_stride, 32'd2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule